// File: doc/BRIEF.md
# Accumulator Machine Execution Core

This block is a small processor core built around a single implicit accumulator. Each instruction names exactly one data-memory location. The accumulator is the other operand of every arithmetic operation and also receives its result. The core holds its own instruction memory and data memory as register arrays. Both are filled through a preload port while the core is idle.

A start pulse resets the program counter and the accumulator and begins fetching at address 0. Every instruction passes through three phases: fetch, operand read, and execute/writeback. A halt instruction ends the run and raises a done flag. The accumulator is always visible at the ports. A program can therefore confirm a stored value by loading it back and reading the accumulator once the core halts.

Top module: `acc_core`

## Requirements
- R1: After a synchronous reset, `acc` reads 0 and `done` reads 0. The core stays idle until a start pulse arrives.
- R2: A start pulse clears `acc` and `done`, sets the program counter to 0 and begins execution. Every instruction takes exactly three cycles. For a program of n instructions that ends in a halt, `done` is high 3n clock edges after the edge that sampled `start`.
- R3: An instruction word has the opcode in bits [15:8] and the data address in bits [7:0]. Opcode 0x01 (load) copies the data word at the address into `acc`. Opcode 0x02 (store) writes `acc` into the data word at the address.
- R4: Opcode 0x03 (add) replaces `acc` with `acc` plus the data word, modulo 2^16.
- R5: Opcode 0x04 (subtract) replaces `acc` with `acc` minus the data word, modulo 2^16. The operand order is never reversed.
- R6: Opcode 0x05 (multiply) replaces `acc` with the low 16 bits of the product of `acc` and the data word.
- R7: Opcode 0xFF (halt) stops fetching and sets `done`. `done` and `acc` then hold their values until the next reset or start pulse.
- R8: Any other opcode leaves `acc` and data memory unchanged, and the program counter still advances to the next instruction.
- R9: While `load_en` is high and the core is idle, the word at `load_addr` is written with `load_data`. `load_imem` = 1 selects instruction memory and 0 selects data memory. Preload writes made while the core is running are ignored.
- R10: The program load C, mult D, add B, sub E, add F, add A, store A leaves C*D+B-E+F+A, modulo 2^16, in location A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins execution at address 0 |
| load_en | input | 1 | Preload write enable, honoured only while idle |
| load_imem | input | 1 | Preload target: 1 = instruction memory, 0 = data memory |
| load_addr | input | 8 | Preload word address |
| load_data | input | 16 | Preload word value |
| done | output | 1 | High after a halt has executed |
| acc | output | 16 | Current accumulator value |

## Verification
A corrupted instruction register or a wrong phase counter shows up in the cycle count to `done`. The bench measures that count exactly, so a single skipped or extra phase is caught at the end of the program it occurs in. A wrong operand latch, a wrong ALU path or a misplaced store changes the accumulator value that is read after the halt. The bench compares that value against arithmetic it computes itself, over a sweep of operand pairs for each operation. A store is only visible at the ports when a later load brings the value back. Programs therefore reload stored locations after first loading an unrelated word, so a missing or misdirected store is exposed within the same run.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int OP_W = 8,
  parameter int AW   = 8,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load_en,
  input  logic          load_imem,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic          done,
  output logic [DW-1:0] acc
);
  localparam int IW    = OP_W + AW;
  localparam int DEPTH = 1 << AW;
  localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(8'h01);
  localparam logic [OP_W-1:0] OP_STORE = OP_W'(8'h02);
  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(8'h03);
  localparam logic [OP_W-1:0] OP_SUB   = OP_W'(8'h04);
  localparam logic [OP_W-1:0] OP_MULT  = OP_W'(8'h05);
  localparam logic [OP_W-1:0] OP_HALT  = {OP_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_READ, S_EXEC} phase_t;

  logic [IW-1:0]   imem [DEPTH];
  logic [DW-1:0]   dmem [DEPTH];
  phase_t          ph;
  logic [AW-1:0]   pc;
  logic [IW-1:0]   ir;
  logic [DW-1:0]   opnd;
  logic [DW-1:0]   nxt;
  logic [OP_W-1:0] op;
  logic [AW-1:0]   ea;
  logic            host_wr;
  logic            is_exec;

  assign op      = ir[IW-1:AW];
  assign ea      = ir[AW-1:0];
  assign host_wr = load_en && (ph == S_IDLE);
  assign is_exec = (ph == S_EXEC);

  always_ff @(posedge clk)
    if (host_wr && load_imem) imem[load_addr] <= IW'(load_data);

  always_ff @(posedge clk)
    if (host_wr && !load_imem) dmem[load_addr] <= load_data;
    else if (is_exec && op == OP_STORE && !start && !rst) dmem[ea] <= acc;

  always_comb begin
    case (op)
      OP_LOAD: nxt = opnd;
      OP_ADD:  nxt = acc + opnd;
      OP_SUB:  nxt = acc - opnd;
      OP_MULT: nxt = acc * opnd;
      default: nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= S_IDLE;
      pc   <= '0;
      ir   <= '0;
      opnd <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else if (start) begin
      ph   <= S_FETCH;
      pc   <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      case (ph)
        S_FETCH: begin
          ir <= imem[pc];
          ph <= S_READ;
        end
        S_READ: begin
          opnd <= dmem[ea];
          ph   <= S_EXEC;
        end
        S_EXEC: begin
          acc <= nxt;
          if (op == OP_HALT) begin
            done <= 1'b1;
            ph   <= S_IDLE;
          end else begin
            pc <= pc + AW'(1);
            ph <= S_FETCH;
          end
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  a_r2_fetch_to_read: assert property (@(posedge clk) disable iff (rst)
    (ph == S_FETCH && !start) |=> (ph == S_READ));
  a_r2_read_to_exec: assert property (@(posedge clk) disable iff (rst)
    (ph == S_READ && !start) |=> (ph == S_EXEC));
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (acc == '0 && !done && pc == '0));
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(acc)));
  a_r7_halt_sets_done: assert property (@(posedge clk) disable iff (rst)
    (is_exec && op == OP_HALT && !start) |=> done);
  a_r8_pc_steps: assert property (@(posedge clk) disable iff (rst)
    (is_exec && op != OP_HALT && !start) |=> (pc == $past(pc) + AW'(1)));
  a_r3_acc_only_in_exec: assert property (@(posedge clk) disable iff (rst)
    (!is_exec && !start) |=> $stable(acc));
  a_r7_idle_when_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (ph == S_IDLE));
endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        load_en = 1'b0;
  logic        load_imem = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic        done;
  logic [15:0] acc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [7:0] LD = 8'h01, ST = 8'h02, AD = 8'h03, SB = 8'h04, ML = 8'h05, HL = 8'hFF;

  acc_core u_acc_core (.clk(clk), .rst(rst), .start(start), .load_en(load_en),
    .load_imem(load_imem), .load_addr(load_addr), .load_data(load_data),
    .done(done), .acc(acc));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit to_imem, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    load_en = 1'b1; load_imem = to_imem; load_addr = a; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [7:0] o, input logic [7:0] a);
    put(1'b1, 8'(idx), {o, a});
  endtask

  task automatic run(output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk); cyc++;
    end
  endtask

  initial begin
    int cyc;
    logic [15:0] va, vb, vc, vd, ve, vf, e16;
    logic [15:0] vals [8];
    logic [31:0] seed;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'hFFFE; vals[6] = 16'hFFFF; vals[7] = 16'h1234;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(acc == 16'h0 && done == 1'b0, "R1 reset state", {acc, 15'b0, done}, 32'h0);

    // R10 expression program, several value sets
    prog(0, LD, 8'd12); prog(1, ML, 8'd13); prog(2, AD, 8'd11); prog(3, SB, 8'd14);
    prog(4, AD, 8'd15); prog(5, AD, 8'd10); prog(6, ST, 8'd10); prog(7, LD, 8'd20);
    prog(8, LD, 8'd10); prog(9, HL, 8'd0);
    put(1'b0, 8'd20, 16'h0000);
    seed = 32'h1357_9BDF;
    for (int s = 0; s < 6; s++) begin
      seed = seed * 32'd1103515245 + 32'd12345; va = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345; vb = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345; vc = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345; vd = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345; ve = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345; vf = seed[31:16];
      put(1'b0, 8'd10, va); put(1'b0, 8'd11, vb); put(1'b0, 8'd12, vc);
      put(1'b0, 8'd13, vd); put(1'b0, 8'd14, ve); put(1'b0, 8'd15, vf);
      e16 = 16'((32'(vc) * 32'(vd)) + 32'(vb) - 32'(ve) + 32'(vf) + 32'(va));
      run(cyc);
      chk(acc == e16, "R10 stored expression", 32'(acc), 32'(e16));
      chk(cyc == 30, "R2 ten-instruction timing", cyc, 30);
    end

    // R7 halt holds
    e16 = acc;
    repeat (5) @(negedge clk);
    chk(done == 1'b1 && acc == e16, "R7 done and acc held", {acc, 15'b0, done}, {e16, 16'h1});

    // R2 start clears acc: single halt program
    prog(0, HL, 8'd0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R2 start drops done", 32'(done), 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(acc == 16'h0, "R2 start clears acc", 32'(acc), 0);
    chk(cyc == 3, "R2 halt-only timing", cyc, 3);

    // R4 R5 R6 operator sweeps
    prog(0, LD, 8'd1); prog(2, HL, 8'd0);
    for (int o = 0; o < 3; o++) begin
      prog(1, (o == 0) ? AD : (o == 1) ? SB : ML, 8'd2);
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          put(1'b0, 8'd1, vals[i]); put(1'b0, 8'd2, vals[j]);
          run(cyc);
          if (o == 0) begin
            e16 = 16'(32'(vals[i]) + 32'(vals[j]));
            chk(acc == e16 && cyc == 9, "R4 add", 32'(acc), 32'(e16));
          end else if (o == 1) begin
            e16 = 16'(32'(vals[i]) - 32'(vals[j]));
            chk(acc == e16 && cyc == 9, "R5 subtract order", 32'(acc), 32'(e16));
          end else begin
            e16 = 16'(32'(vals[i]) * 32'(vals[j]));
            chk(acc == e16 && cyc == 9, "R6 multiply low half", 32'(acc), 32'(e16));
          end
        end
    end

    // R3 store then reload after an unrelated load
    put(1'b0, 8'd1, 16'hBEEF); put(1'b0, 8'd0, 16'h5555); put(1'b0, 8'd30, 16'h0000);
    prog(0, LD, 8'd1); prog(1, ST, 8'd30); prog(2, LD, 8'd0); prog(3, LD, 8'd30); prog(4, HL, 8'd0);
    run(cyc);
    chk(acc == 16'hBEEF, "R3 store and load", 32'(acc), 32'hBEEF);
    chk(cyc == 15, "R3 timing", cyc, 15);

    // R8 undefined opcode is a no-op and pc advances
    put(1'b0, 8'd2, 16'h0042);
    prog(0, LD, 8'd1); prog(1, 8'h77, 8'd2); prog(2, 8'h00, 8'd2); prog(3, HL, 8'd0);
    run(cyc);
    chk(acc == 16'hBEEF, "R8 undefined keeps acc", 32'(acc), 32'hBEEF);
    chk(cyc == 12, "R8 pc advances past undefined", cyc, 12);
    prog(0, LD, 8'd1); prog(1, 8'h77, 8'd2); prog(2, LD, 8'd2); prog(3, HL, 8'd0);
    run(cyc);
    chk(acc == 16'h0042, "R8 undefined leaves memory", 32'(acc), 32'h42);

    // R9 preload writes ignored while running
    prog(0, 8'h00, 8'd0); prog(1, 8'h00, 8'd0); prog(2, LD, 8'd1); prog(3, HL, 8'd0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    load_en = 1'b1; load_imem = 1'b0; load_addr = 8'd1; load_data = 16'hDEAD;
    @(negedge clk);
    load_imem = 1'b1; load_addr = 8'd2; load_data = {HL, 8'd0};
    @(negedge clk);
    load_en = 1'b0;
    cyc = 2;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(acc == 16'hBEEF, "R9 data write while running ignored", 32'(acc), 32'hBEEF);
    chk(cyc == 12, "R9 instruction write while running ignored", cyc, 12);

    // R1 reset clears after a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(acc == 16'h0 && done == 1'b0, "R1 reset after run", {acc, 15'b0, done}, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule